// File: doc/BRIEF.md
# Serial ROM Identifier CRC-8 Checker

This block validates the 64-bit identifier read back from a single-wire bus device. Each accepted bit updates an 8-bit reflected LFSR with polynomial x^8+x^5+x^4+1. Bits arrive one per strobe, least significant bit first, and the first byte is the family code. While the bits are arriving, the block stores each one at its position in the identifier. This gives the family code, the 48-bit serial number and the received check byte directly.

A read is good when the LFSR residue is zero after all 64 bits, which include the stored check byte. A phase state machine steps through four states:

- FAMILY (code 0): bits 0 to 7.
- SERIAL (code 1): bits 8 to 55.
- CHECK (code 2): bits 56 to 63.
- DONE (code 3): the read is complete.

The transitions are:

- FAMILY to SERIAL on the 8th accepted bit.
- SERIAL to CHECK on the 56th accepted bit.
- CHECK to DONE on the 64th accepted bit.
- Any state back to FAMILY on the clear input.

In DONE the block ignores strobes. When the 56th bit is accepted, the block saves the CRC computed over the data bytes. This lets the computed value be compared with the received byte.

Top module: `rom_crc8_checker`

## Requirements
- R1: After reset, or one cycle after clear_i is high, crc_o, bit_count_o, calc_crc_o, family_o, serial_o and rx_crc_o are all zero, done_o and valid_o are low, and phase_o is 0.
- R2: Each accepted bit (bit_valid_i high, clear_i low, not in DONE) adds one to bit_count_o. It also updates crc_o: f = crc[0] xor bit; crc becomes (crc >> 1) xor (f ? 0x8C : 0x00).
- R3: Accepted bit number k (k = 0 to 63, counting from 0) is stored at identifier position k. family_o is positions 7..0, serial_o is positions 55..8 and rx_crc_o is positions 63..56.
- R4: done_o rises in the cycle after the 64th accepted bit, and bit_count_o is then 64.
- R5: valid_o is high only while done_o is high and crc_o is 0x00. A corrupted identifier leaves valid_o low.
- R6: In DONE, strobes change no output until clear_i.
- R7: calc_crc_o holds the CRC over the first 56 bits once those bits are in, and stays fixed until clear.
- R8: When clear_i and bit_valid_i are high in the same cycle, the clear wins and the bit is discarded.
- R9: A cycle with bit_valid_i and clear_i both low changes no output.
- R10: phase_o follows the codes 0 FAMILY, 1 SERIAL, 2 CHECK, 3 DONE, and changes at the bit boundaries 8, 56 and 64.
- R11: The identifier with family 0x02 and serial 0x00000001B81C gives crc_o 0xA2 after 56 bits and 0x00 after 64 bits. Feeding the ones' complement of crc_o as the next 8 bits leaves crc_o at 0x35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new read (synchronous clear) |
| bit_valid_i | input | 1 | Strobe qualifying bit_i |
| bit_i | input | 1 | Serial identifier bit, LSB first |
| crc_o | output | 8 | Running LFSR contents |
| bit_count_o | output | 7 | Number of accepted bits |
| phase_o | output | 2 | State code: 0 FAMILY, 1 SERIAL, 2 CHECK, 3 DONE |
| done_o | output | 1 | All 64 bits received |
| valid_o | output | 1 | Done with zero residue |
| family_o | output | 8 | Captured family code |
| serial_o | output | 48 | Captured serial number |
| rx_crc_o | output | 8 | Captured received check byte |
| calc_crc_o | output | 8 | CRC computed over the first 56 bits |

## Verification
Every result is registered. A strobe sampled at one rising edge shows on all outputs at that edge, including crc_o, the captured fields, phase_o, done_o and valid_o. The bench therefore drives at the falling edge and compares at the next falling edge, one full cycle later. A behavioural model holds the received bit list and recomputes the residue and the fields from that list. The model is updated together with each drive and compared with every output on every clock.

// File: rtl/rom_crc_pkg.sv
package rom_crc_pkg;

    typedef enum logic [1:0] {
        ST_FAMILY = 2'd0,
        ST_SERIAL = 2'd1,
        ST_CHECK  = 2'd2,
        ST_DONE   = 2'd3
    } rom_phase_e;

endpackage

// File: rtl/crc_serial_lfsr.sv
module crc_serial_lfsr #(
    parameter int              CRC_W     = 8,
    parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o,
    output logic [CRC_W-1:0] crc_next_o
);

    logic [CRC_W-1:0] crc_q;
    logic             feedback;

    always_comb begin
        feedback   = crc_q[0] ^ bit_i;
        crc_next_o = (crc_q >> 1) ^ (feedback ? POLY_REFL : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          crc_q <= '0;
        else if (clear_i)    crc_q <= '0;
        else if (shift_en_i) crc_q <= crc_next_o;
    end

    assign crc_o = crc_q;

    // R9: no shift, no clear -> register holds
    p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && !clear_i) |=> $stable(crc_o));

endmodule

// File: rtl/rom_bit_counter.sv
module rom_bit_counter #(
    parameter int LIMIT = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (inc_i && (cnt_q < CNT_W'(LIMIT))) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(LIMIT));

endmodule

// File: rtl/rom_field_capture.sv
module rom_field_capture #(
    parameter int ROM_BITS = 64,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                bit_i,
    output logic [ROM_BITS-1:0] rom_o
);

    logic [ROM_BITS-1:0] rom_q;

    for (genvar g = 0; g < ROM_BITS; g++) begin : g_pos
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                rom_q[g] <= 1'b0;
            else if (clear_i)                          rom_q[g] <= 1'b0;
            else if (wr_en_i && (idx_i == IDX_W'(g)))  rom_q[g] <= bit_i;
        end
    end

    assign rom_o = rom_q;

    // R3: a write touches only the addressed position
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i && idx_i != '0) |=> (rom_o[0] == $past(rom_o[0])));

endmodule

// File: rtl/rom_crc8_checker.sv
module rom_crc8_checker #(
    parameter int               FAMILY_W = 8,
    parameter int               SERIAL_W = 48,
    parameter int               CRC_W    = 8,
    parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C,
    parameter int               CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                bit_valid_i,
    input  logic                bit_i,
    output logic [CRC_W-1:0]    crc_o,
    output logic [CNT_W-1:0]    bit_count_o,
    output logic [1:0]          phase_o,
    output logic                done_o,
    output logic                valid_o,
    output logic [FAMILY_W-1:0] family_o,
    output logic [SERIAL_W-1:0] serial_o,
    output logic [CRC_W-1:0]    rx_crc_o,
    output logic [CRC_W-1:0]    calc_crc_o
);
    import rom_crc_pkg::*;

    localparam int ROM_BITS = FAMILY_W + SERIAL_W + CRC_W;
    localparam int SNAP_AT  = FAMILY_W + SERIAL_W;
    localparam int IDX_W    = $clog2(ROM_BITS);

    rom_phase_e          state_q, state_d;
    logic                accept;
    logic [CRC_W-1:0]    crc_next;
    logic [CRC_W-1:0]    snap_q;
    logic [ROM_BITS-1:0] rom_bits;

    assign accept = bit_valid_i && !clear_i && (state_q != ST_DONE);

    crc_serial_lfsr #(.CRC_W(CRC_W), .POLY_REFL(POLY_REFL)) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .shift_en_i (accept),
        .bit_i      (bit_i),
        .crc_o      (crc_o),
        .crc_next_o (crc_next)
    );

    rom_bit_counter #(.LIMIT(ROM_BITS), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .inc_i   (accept),
        .count_o (bit_count_o)
    );

    rom_field_capture #(.ROM_BITS(ROM_BITS), .IDX_W(IDX_W)) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .wr_en_i (accept),
        .idx_i   (bit_count_o[IDX_W-1:0]),
        .bit_i   (bit_i),
        .rom_o   (rom_bits)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAMILY: if (accept && bit_count_o == CNT_W'(FAMILY_W - 1)) state_d = ST_SERIAL;
            ST_SERIAL: if (accept && bit_count_o == CNT_W'(SNAP_AT - 1))  state_d = ST_CHECK;
            ST_CHECK:  if (accept && bit_count_o == CNT_W'(ROM_BITS - 1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
        endcase
        if (clear_i) state_d = ST_FAMILY;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAMILY;
        else        state_q <= state_d;
    end

    // Snapshot of the CRC over the data bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (clear_i) snap_q <= '0;
        else if (accept && bit_count_o == CNT_W'(SNAP_AT - 1)) snap_q <= crc_next;
    end

    // Outputs
    always_comb begin
        phase_o    = state_q;
        done_o     = (state_q == ST_DONE);
        valid_o    = (state_q == ST_DONE) && (crc_o == '0);
        family_o   = rom_bits[FAMILY_W-1:0];
        serial_o   = rom_bits[SNAP_AT-1:FAMILY_W];
        rx_crc_o   = rom_bits[ROM_BITS-1:SNAP_AT];
        calc_crc_o = snap_q;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (bit_count_o == '0 && crc_o == '0 && !done_o && calc_crc_o == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !clear_i && !done_o) |=> (bit_count_o == $past(bit_count_o) + 1'b1));

    p_done_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bit_count_o == CNT_W'(ROM_BITS)));

    p_valid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (done_o && crc_o == '0));

    p_hold_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> (done_o && $stable(crc_o) && $stable(rx_crc_o)));

    p_snap_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_count_o >= CNT_W'(SNAP_AT) && !clear_i) |=> $stable(calc_crc_o));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && bit_valid_i) |=> (bit_count_o == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid_i && !clear_i) |=> ($stable(bit_count_o) && $stable(phase_o)));

    p_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |-> (bit_count_o >= CNT_W'(SNAP_AT) && bit_count_o < CNT_W'(ROM_BITS)));

endmodule

// File: tb/rom_crc8_checker_test.sv
module rom_crc8_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [7:0]  crc_o;
    logic [6:0]  bit_count_o;
    logic [1:0]  phase_o;
    logic        done_o, valid_o;
    logic [7:0]  family_o;
    logic [47:0] serial_o;
    logic [7:0]  rx_crc_o, calc_crc_o;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [63:0] m_rom = '0;
    int          m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_crc8_checker uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .bit_valid_i(bit_valid_i),
        .bit_i(bit_i), .crc_o(crc_o), .bit_count_o(bit_count_o), .phase_o(phase_o),
        .done_o(done_o), .valid_o(valid_o), .family_o(family_o), .serial_o(serial_o),
        .rx_crc_o(rx_crc_o), .calc_crc_o(calc_crc_o)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] bits, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            c = c ^ {7'd0, bits[i]};
            if (c[0]) c = (c >> 1) ^ 8'h8C;
            else      c = c >> 1;
        end
        return c;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic compare_all();
        logic [1:0] ph;
        ph = (m_cnt < 8) ? 2'd0 : (m_cnt < 56) ? 2'd1 : (m_cnt < 64) ? 2'd2 : 2'd3;
        chk(crc_o, ref_crc(m_rom, m_cnt), "R2 crc");
        chk(bit_count_o, m_cnt, "R2 count");
        chk(family_o, m_rom[7:0], "R3 family");
        chk(serial_o, m_rom[55:8], "R3 serial");
        chk(rx_crc_o, m_rom[63:56], "R3 rx_crc");
        chk(done_o, m_cnt == 64, "R4 done");
        chk(valid_o, (m_cnt == 64) && (ref_crc(m_rom, 64) == 8'h00), "R5 valid");
        chk(calc_crc_o, (m_cnt >= 56) ? ref_crc(m_rom, 56) : 8'h00, "R7 calc");
        chk(phase_o, ph, "R10 phase");
    endtask

    // called at a falling edge
    task automatic step(input logic v, input logic b, input logic c);
        bit_valid_i = v; bit_i = b; clear_i = c;
        if (c) begin m_cnt = 0; m_rom = '0; end
        else if (v && m_cnt < 64) begin m_rom[m_cnt] = b; m_cnt++; end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic feed_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) step(1'b1, d[i], 1'b0);
    endtask

    task automatic feed_rom(input logic [63:0] r);
        for (int i = 0; i < 64; i++) step(1'b1, r[i], 1'b0);
    endtask

    function automatic logic [63:0] good_rom(input logic [55:0] data);
        logic [63:0] t = {8'h00, data};
        return {ref_crc(t, 56), data};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(crc_o, 0, "R1 reset crc");
        chk(done_o, 0, "R1 reset done");
        compare_all();

        // R11 known identifier
        r = {8'hA2, 48'h00000001B81C, 8'h02};
        for (int i = 0; i < 56; i++) step(1'b1, r[i], 1'b0);
        chk(crc_o, 8'hA2, "R11 crc after 56");
        chk(calc_crc_o, 8'hA2, "R7 snapshot");
        for (int i = 56; i < 64; i++) step(1'b1, r[i], 1'b0);
        chk(crc_o, 8'h00, "R11 residue");
        chk(valid_o, 1'b1, "R5 good read");
        chk(family_o, 8'h02, "R3 family value");
        chk(serial_o, 48'h00000001B81C, "R3 serial value");

        // R6 strobes after done are ignored
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
        chk(bit_count_o, 64, "R6 count held");
        chk(crc_o, 8'h00, "R6 crc held");
        // R9 idle
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        chk(done_o, 1'b1, "R9 idle keeps done");

        // R8 clear with strobe
        step(1'b1, 1'b1, 1'b1);
        chk(bit_count_o, 0, "R8 clear wins");
        chk(family_o, 0, "R1 clear fields");

        // R5 corrupted identifier
        r = good_rom(56'h00_0000_01B8_1C02) ^ 64'h0000_0100_0000_0000;
        feed_rom(r);
        chk(valid_o, 1'b0, "R5 corrupt read");
        chk(done_o, 1'b1, "R4 done on corrupt");
        step(1'b0, 1'b0, 1'b1);

        // clear mid-read (R1)
        feed_byte(8'h5A);
        feed_byte(8'h33);
        step(1'b0, 1'b0, 1'b1);
        chk(crc_o, 0, "R1 mid clear");

        // R11 complement self-test
        feed_byte(8'h41);
        feed_byte(8'h9E);
        feed_byte(~crc_o);
        chk(crc_o, 8'h35, "R11 complement");
        step(1'b0, 1'b0, 1'b1);

        // random good identifiers with gaps in strobes
        for (int k = 0; k < 20; k++) begin
            r = good_rom({$urandom(), $urandom()});
            for (int i = 0; i < 64; i++) begin
                if (($urandom() & 3) == 0) step(1'b0, 1'b0, 1'b0);
                step(1'b1, r[i], 1'b0);
            end
            chk(valid_o, 1'b1, "R5 random good");
            chk(rx_crc_o, r[63:56], "R3 random rx");
            step(1'b0, 1'b0, 1'b1);
        end

        summary();
        $finish;
    end

endmodule